// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block owns the program counter of a small controller whose instructions are 13 bits wide. Every clock cycle it looks at the instruction being executed and picks the next PC. Most instructions simply advance the PC by one. The two long-branch forms load the PC from a 2-bit page input joined to a 10-bit immediate, and the call form also saves the return address. The two return forms restore the PC from a hardware return-address stack. The block also keeps the global interrupt-enable flag, which three instructions change.

A skip request from the execution unit marks the following sequential instruction as squashed. That instruction is still fetched, but it behaves as a no-operation, so a skip costs one extra cycle and the PC ends up two words further on. The return stack holds eight entries and is circular. A ninth push overwrites the oldest entry, and a pop from an empty stack wraps the pointer round and returns whatever that slot holds.

Top module: `pcs_top`

## Requirements
- R1: While reset is asserted (`rst_n` low), and on release, PC = 0, stack pointer = 0, every stack entry and so `tos` = 0, `int_en` = 0 and `squash` = 0.
- R2: An instruction that is none of the forms below (for example 0x0000, 0x0001, or bit 12 set with bits 11:10 = 10 or 11) advances the PC by one and leaves the stack pointer, `tos` and `int_en` unchanged.
- R3: An instruction with bits 12:10 = 101 (long jump) loads the PC with {page, bits 9:0} and leaves the stack unchanged.
- R4: An instruction with bits 12:10 = 100 (call) writes PC+1 into the stack slot at the pointer, increments the pointer, and loads the PC with {page, bits 9:0}. After it, `tos` equals the saved return address.
- R5: Instruction 0x0012 (return) decrements the stack pointer and loads the PC with the entry it then points at (the old `tos`). `int_en` is unchanged.
- R6: Instruction 0x0013 (return from interrupt) does the same as R5 and also sets `int_en` to 1.
- R7: Instruction 0x0010 sets `int_en` to 1. Instruction 0x0011 clears it to 0. Neither moves the stack.
- R8: `skip_req` high in an unsquashed cycle sets `squash` in the next cycle. In the squashed cycle the instruction present has no effect at all (no branch, push, pop or enable change) and the PC advances by one.
- R9: `skip_req` during a squashed cycle is ignored: `squash` is 0 in the following cycle.
- R10: The stack pointer is 3 bits and wraps from 7 to 0 on push, so a ninth unmatched push overwrites the oldest entry.
- R11: A pop with the pointer at 0 wraps the pointer to 7 and returns entry 7.
- R12: PC arithmetic is 12 bits. Advancing from 0xFFF gives 0x000, and a call executed at 0xFFF saves 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 13 | Instruction executing in this cycle |
| skip_req | input | 1 | Execution unit asks to squash the next instruction |
| page | input | 2 | Page bits used as the PC's upper bits on jump and call |
| pc | output | 12 | Current program counter |
| sp | output | 3 | Return-stack pointer (next free slot) |
| tos | output | 12 | Entry just below the pointer (most recent return address) |
| int_en | output | 1 | Global interrupt enable |
| squash | output | 1 | The current instruction is being treated as a no-operation |

## Verification
The delicate overlap is a squashed slot that falls on a cycle where a control-transfer or enable instruction sits at the block's input. The bench provokes it by raising `skip_req` on a plain instruction and then presenting a call, a return, an enable, or another `skip_req` in the very next cycle. It judges the result by checking that the PC moved by exactly one and that pointer, `tos`, `int_en` and the following `squash` are all left untouched. It also combines `skip_req` with a jump in one cycle, and expects the jump to land and the target's instruction to be squashed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int INSTR_W = 13;

    localparam logic [INSTR_W-1:0] ENC_ENI  = 13'h0010;
    localparam logic [INSTR_W-1:0] ENC_DISI = 13'h0011;
    localparam logic [INSTR_W-1:0] ENC_RET  = 13'h0012;
    localparam logic [INSTR_W-1:0] ENC_RETI = 13'h0013;

    typedef enum logic [2:0] {
        OP_SEQ,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_RETI,
        OP_ENI,
        OP_DISI
    } flow_op_e;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int IMM_W = 10
) (
    input  logic [INSTR_W-1:0] instr,
    output flow_op_e           op,
    output logic [IMM_W-1:0]   imm
);

    localparam int LONG_BIT = INSTR_W - 1;

    always_comb begin
        op  = OP_SEQ;
        imm = instr[IMM_W-1:0];
        if (instr[LONG_BIT]) begin
            unique case (instr[LONG_BIT-1:LONG_BIT-2])
                2'b00:   op = OP_CALL;
                2'b01:   op = OP_JMP;
                default: op = OP_SEQ;
            endcase
        end else begin
            unique case (instr)
                ENC_ENI:  op = OP_ENI;
                ENC_DISI: op = OP_DISI;
                ENC_RET:  op = OP_RET;
                ENC_RETI: op = OP_RETI;
                default:  op = OP_SEQ;
            endcase
        end
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic [W-1:0]             push_data,
    output logic [$clog2(DEPTH)-1:0] sp,
    output logic [W-1:0]             tos
);

    localparam int SP_W = $clog2(DEPTH);

    typedef struct packed {
        logic [SP_W-1:0]           sp;
        logic [DEPTH-1:0][W-1:0]   mem;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [SP_W-1:0] sp_dec;

    assign sp_dec = stk_q.sp - SP_W'(1);

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.mem[stk_q.sp] = push_data;
            stk_d.sp            = stk_q.sp + SP_W'(1);
        end else if (pop) begin
            stk_d.sp = sp_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign sp  = stk_q.sp;
    assign tos = stk_q.mem[sp_dec];

    a_r10_push_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sp == $past(sp) + SP_W'(1)) && (tos == $past(push_data)));

    a_r5_pop_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp == $past(sp) - SP_W'(1));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp) && $stable(tos));

    always_comb begin
        if (rst_n) a_r4_push_pop_excl: assert (!(push && pop));
    end

endmodule

// File: rtl/pcs_top.sv
module pcs_top
    import pcs_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int IMM_W  = 10,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INSTR_W-1:0]       instr,
    input  logic                     skip_req,
    input  logic [PAGE_W-1:0]        page,
    output logic [PAGE_W+IMM_W-1:0]  pc,
    output logic [$clog2(DEPTH)-1:0] sp,
    output logic [PAGE_W+IMM_W-1:0]  tos,
    output logic                     int_en,
    output logic                     squash
);

    localparam int PC_W = PAGE_W + IMM_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            ie;
        logic            sq;
    } seq_t;

    seq_t seq_d, seq_q;

    flow_op_e         dec_op, eff_op;
    logic [IMM_W-1:0] imm;
    logic [PC_W-1:0]  pc_inc, target;
    logic             do_push, do_pop;

    pcs_decode #(.IMM_W(IMM_W)) u_dec (
        .instr (instr),
        .op    (dec_op),
        .imm   (imm)
    );

    pcs_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc),
        .sp        (sp),
        .tos       (tos)
    );

    assign pc_inc = seq_q.pc + PC_W'(1);
    assign target = {page, imm};
    assign eff_op = seq_q.sq ? OP_SEQ : dec_op;
    assign do_push = (eff_op == OP_CALL);
    assign do_pop  = (eff_op == OP_RET) || (eff_op == OP_RETI);

    always_comb begin
        seq_d    = seq_q;
        seq_d.pc = pc_inc;
        seq_d.sq = !seq_q.sq && skip_req;
        unique case (eff_op)
            OP_JMP, OP_CALL: seq_d.pc = target;
            OP_RET:          seq_d.pc = tos;
            OP_RETI: begin
                seq_d.pc = tos;
                seq_d.ie = 1'b1;
            end
            OP_ENI:          seq_d.ie = 1'b1;
            OP_DISI:         seq_d.ie = 1'b0;
            default:         ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pc     = seq_q.pc;
    assign int_en = seq_q.ie;
    assign squash = seq_q.sq;

    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && instr[INSTR_W-1 -: 3] == 3'b101)
        |=> (pc == {$past(page), $past(instr[IMM_W-1:0])}) && $stable(sp));

    a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && instr[INSTR_W-1 -: 3] == 3'b100)
        |=> (pc == {$past(page), $past(instr[IMM_W-1:0])}) && (tos == $past(pc) + PC_W'(1)));

    a_r6_reti_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && instr == ENC_RETI) |=> int_en && (pc == $past(tos)));

    a_r7_disi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && instr == ENC_DISI) |=> !int_en);

    a_r8_squash_inert: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (pc == $past(pc) + PC_W'(1)) && $stable(sp) && $stable(int_en));

    a_r9_no_chain: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash);

endmodule

// File: tb/tb_pcs_top.sv
module tb_pcs_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] instr = '0;
    logic        skip_req = 1'b0;
    logic [1:0]  page = '0;
    logic [11:0] pc, tos;
    logic [2:0]  sp;
    logic        int_en, squash;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // bench-side expectation, built from the requirements
    logic [11:0] m_pc;
    logic [2:0]  m_sp;
    logic [11:0] m_stk [8];
    logic        m_ie, m_sq;

    always #5 clk = ~clk;

    pcs_top dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .skip_req(skip_req), .page(page),
        .pc(pc), .sp(sp), .tos(tos), .int_en(int_en), .squash(squash)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "sp", sp, m_sp);
        chk(tag, "tos", tos, m_stk[m_sp - 3'd1]);
        chk(tag, "int_en", int_en, m_ie);
        chk(tag, "squash", squash, m_sq);
    endtask

    task automatic model_reset();
        m_pc = '0; m_sp = '0; m_ie = 0; m_sq = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    // apply one instruction for one cycle and update the expectation
    task automatic step(input logic [12:0] ins, input logic sk, input logic [1:0] pg);
        logic [11:0] nxt;
        @(negedge clk);
        instr = ins; skip_req = sk; page = pg;
        nxt = m_pc + 12'd1;
        if (!m_sq) begin
            if (ins[12:10] == 3'b101) nxt = {pg, ins[9:0]};
            else if (ins[12:10] == 3'b100) begin
                m_stk[m_sp] = m_pc + 12'd1; m_sp = m_sp + 3'd1; nxt = {pg, ins[9:0]};
            end else if (ins == 13'h0012 || ins == 13'h0013) begin
                m_sp = m_sp - 3'd1; nxt = m_stk[m_sp];
                if (ins == 13'h0013) m_ie = 1;
            end else if (ins == 13'h0010) m_ie = 1;
            else if (ins == 13'h0011) m_ie = 0;
        end
        m_sq = !m_sq && sk;
        m_pc = nxt;
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; instr = '0; skip_req = 0;
        model_reset();
        @(posedge clk); #1;
        chk_all("R1");
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1; // instr 0 executes: pc 1
        m_pc = 12'd1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_all("R1");
    endtask

    task automatic t_seq();
        step(13'h0000, 0, 2'd0); chk_all("R2");
        step(13'h0001, 0, 2'd3); chk_all("R2");
        step(13'h1800, 0, 2'd1); chk_all("R2");
        step(13'h1FFF, 0, 2'd2); chk_all("R2");
        chk("R2", "pc", pc, 12'd5);
    endtask

    task automatic t_jmp();
        step(13'h1555, 0, 2'd2); chk_all("R3");
        chk("R3", "pc", pc, 12'h955);
    endtask

    task automatic t_call_ret();
        step(13'h100A, 0, 2'd1); chk_all("R4");
        chk("R4", "tos", tos, 12'h956);
        step(13'h0012, 0, 2'd0); chk_all("R5");
        chk("R5", "pc", pc, 12'h956);
    endtask

    task automatic t_ie();
        step(13'h0010, 0, 2'd0); chk_all("R7");
        step(13'h0011, 0, 2'd0); chk_all("R7");
        step(13'h1020, 0, 2'd0); chk_all("R4");
        step(13'h0012, 0, 2'd0); chk_all("R5");
        chk("R5", "int_en", int_en, 0);
        step(13'h1030, 0, 2'd0); chk_all("R4");
        step(13'h0013, 0, 2'd0); chk_all("R6");
        chk("R6", "int_en", int_en, 1);
        step(13'h0011, 0, 2'd0); chk_all("R7");
    endtask

    task automatic t_skip();
        logic [11:0] p;
        p = pc;
        step(13'h0000, 1, 2'd0); chk_all("R8");
        step(13'h1001, 0, 2'd2); chk_all("R8");       // squashed call
        chk("R8", "pc", pc, p + 12'd2);
        step(13'h0000, 1, 2'd0); chk_all("R8");
        step(13'h0010, 0, 2'd0); chk_all("R8");       // squashed enable
        step(13'h1040, 0, 2'd0); chk_all("R4");
        step(13'h0000, 1, 2'd0); chk_all("R8");
        step(13'h0012, 0, 2'd0); chk_all("R8");       // squashed return
        step(13'h0000, 1, 2'd0); chk_all("R8");
        step(13'h0000, 1, 2'd0); chk_all("R9");       // skip while squashed
        chk("R9", "squash", squash, 0);
        step(13'h1400, 1, 2'd1); chk_all("R3");        // jump with skip
        step(13'h1400, 0, 2'd3); chk_all("R8");        // squashed jump at target
        chk("R8", "pc", pc, 12'h401);
        step(13'h0012, 0, 2'd0); chk_all("R5");
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 9; i++) begin
            step(13'h1000 | 13'(i * 16), 0, 2'd1); chk_all("R10");
        end
        chk("R10", "sp", sp, 1);
        for (int i = 0; i < 9; i++) begin
            step(13'h0012, 0, 2'd0); chk_all("R10");
        end
        chk("R10", "sp", sp, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        step(13'h0012, 0, 2'd0); chk_all("R11");
        chk("R11", "sp", sp, 7);
        for (int i = 0; i < 8; i++) step(13'h1100 | 13'(i), 0, 2'd2);
        chk_all("R10");
        step(13'h0013, 0, 2'd0); chk_all("R11");
    endtask

    task automatic t_wrap();
        do_reset();
        step(13'h17FF, 0, 2'd3); chk_all("R12");
        step(13'h0000, 0, 2'd0); chk_all("R12");
        chk("R12", "pc", pc, 0);
        step(13'h17FF, 0, 2'd3);
        step(13'h1005, 0, 2'd0); chk_all("R12");
        chk("R12", "tos", tos, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        t_reset();
        t_seq();
        t_jmp();
        t_call_ret();
        t_ie();
        t_skip();
        t_overflow();
        t_underflow();
        t_wrap();
        finish_run();
    end

endmodule